// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decoder

This block takes one 32-bit instruction word per cycle together with the two source register values that were already read for it. It works out which integer operation the word asks for, forms the second operand from either the second source value or a 16-bit immediate, and computes the result. Whether the immediate is sign-extended or zero-extended depends on the opcode.

One clock later it presents the result, the destination register index and a write enable, ready for a register file write port. For load and store words it produces a word-aligned effective address and a read or write strobe. For a store, the result bus carries the data to be stored. Memory itself, the register file and branch handling sit outside the block. Words in the wide format are passed over without effect.

Instruction word fields:
- Bit 31 selects the format. A clear bit means core format.
- Bits 30:25 hold the opcode.
- Bit 24 selects the immediate form.
- Bits 23:20 name source 1. The register file outside the block uses this field.
- In register form, bits 19:16 name source 2 and bits 15:12 name the destination.
- In immediate form, bits 19:16 name the destination and bits 15:0 hold the immediate.

Top module: `int_exec_unit`

## Requirements
- R1: The destination index is taken from bits 15:12 when bit 24 is clear (register form) and from bits 19:16 when bit 24 is set (immediate form). The operand b is the source 2 value in register form and the extended immediate (bits 15:0) in immediate form.
- R2: Opcode 0x00 adds and opcode 0x02 subtracts (src1 - b) in two's complement. In immediate form, both sign-extend the immediate.
- R3: Opcode 0x01 adds and opcode 0x03 subtracts with the immediate zero-extended.
- R4: The logical operations are AND (0x08), OR (0x09), XOR (0x0a), NAND (0x0b), NOR (0x0c) and XNOR (0x0d). All of them zero-extend the immediate.
- R5: Opcode 0x10 shifts left logically, 0x11 shifts right logically and 0x12 shifts right arithmetically. The shift amount is the low 5 bits of b, so amounts of 32 or more wrap modulo 32.
- R6: Opcode 0x04 multiplies the low 16 bits of src1 by the low 16 bits of b. Both are treated as signed values, and the product is returned as a signed 32-bit value.
- R7: Opcode 0x0e with bit 24 set writes the immediate into result bits 31:16 and zero into bits 15:0. With bit 24 clear it is not handled.
- R8: Opcode 0x20 (load) and opcode 0x21 (store) require bit 24 set. The address is src1 plus the sign-extended immediate, with bits 1:0 forced to zero.
  - A load raises the read strobe and reports the destination from bits 19:16, with the write enable low.
  - A store raises the write strobe and puts the source 2 value on the result bus, with the write enable low.
- R9: A word with bit 31 set, or with an opcode or form the unit does not handle, leaves the write enable and both memory strobes low.
- R10: All outputs are registered. The outputs for a valid input appear after the next rising clock edge, and the output valid follows the input valid by one cycle. Without an input valid, the write enable and the strobes stay low.
- R11: The synchronous active-high reset clears the output valid, the write enable and both memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and source values are valid this cycle |
| instr | input | 32 | Instruction word |
| src1_val | input | 32 | Value of source register 1 |
| src2_val | input | 32 | Value of source register 2 |
| out_valid | output | 1 | Registered copy of in_valid |
| dest_idx | output | 4 | Destination register index |
| wr_en | output | 1 | Register write enable |
| result | output | 32 | Integer result, or store data for a store |
| mem_addr | output | 32 | Word-aligned load or store address |
| mem_rd | output | 1 | Load request |
| mem_wr | output | 1 | Store request |

## Verification
Every output of the block is due exactly one rising edge after the cycle in which in_valid is high. Nothing combinational reaches a port, so no result is visible earlier and none is held beyond the following edge unless the input is repeated. Each scenario task drives the word on a falling edge and drops in_valid on the next falling edge. It then compares result, dest_idx, wr_en and the strobes on that same falling edge, halfway between the capturing edge and the one after it.

// File: rtl/ieu_pkg.sv
package ieu_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 4;
  localparam int IMMW = 16;
  localparam int OPW  = 6;
  localparam int SHW  = $clog2(XLEN);
  localparam int ALIGN_BITS = 2;

  typedef enum logic [OPW-1:0] {
    OPC_ADD  = 6'h00, OPC_ADDU = 6'h01, OPC_SUB  = 6'h02, OPC_SUBU = 6'h03,
    OPC_MUL  = 6'h04, OPC_AND  = 6'h08, OPC_OR   = 6'h09, OPC_XOR  = 6'h0a,
    OPC_NAND = 6'h0b, OPC_NOR  = 6'h0c, OPC_XNOR = 6'h0d, OPC_UPI  = 6'h0e,
    OPC_SLL  = 6'h10, OPC_SRL  = 6'h11, OPC_SRA  = 6'h12,
    OPC_LDW  = 6'h20, OPC_STW  = 6'h21
  } opcode_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR,
    FN_SLL, FN_SRL, FN_SRA, FN_MUL, FN_UPI
  } fn_e;

  typedef struct packed {
    fn_e              fn;
    logic             inv;
    logic             sext;
    logic             use_imm;
    logic             wr;
    logic             ld;
    logic             st;
    logic [RIDX-1:0]  dest;
    logic [IMMW-1:0]  imm;
  } ctrl_t;
endpackage

// File: rtl/ieu_decode.sv
module ieu_decode
  import ieu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic    core_fmt;
  logic    imm_form;
  opcode_e opc;
  logic [RIDX-1:0] unused_src1_field;

  assign core_fmt = ~instr[31];
  assign imm_form = instr[24];
  assign opc      = opcode_e'(instr[30:25]);
  assign unused_src1_field = instr[23:20];

  always_comb begin
    ctrl         = '0;
    ctrl.fn      = FN_ADD;
    ctrl.use_imm = imm_form;
    ctrl.imm     = instr[IMMW-1:0];
    ctrl.dest    = imm_form ? instr[19:16] : instr[15:12];
    if (core_fmt) begin
      unique case (opc)
        OPC_ADD:  begin ctrl.fn = FN_ADD; ctrl.sext = 1'b1; ctrl.wr = 1'b1; end
        OPC_SUB:  begin ctrl.fn = FN_SUB; ctrl.sext = 1'b1; ctrl.wr = 1'b1; end
        OPC_ADDU: begin ctrl.fn = FN_ADD; ctrl.wr = 1'b1; end
        OPC_SUBU: begin ctrl.fn = FN_SUB; ctrl.wr = 1'b1; end
        OPC_MUL:  begin ctrl.fn = FN_MUL; ctrl.sext = 1'b1; ctrl.wr = 1'b1; end
        OPC_AND:  begin ctrl.fn = FN_AND; ctrl.wr = 1'b1; end
        OPC_OR:   begin ctrl.fn = FN_OR;  ctrl.wr = 1'b1; end
        OPC_XOR:  begin ctrl.fn = FN_XOR; ctrl.wr = 1'b1; end
        OPC_NAND: begin ctrl.fn = FN_AND; ctrl.inv = 1'b1; ctrl.wr = 1'b1; end
        OPC_NOR:  begin ctrl.fn = FN_OR;  ctrl.inv = 1'b1; ctrl.wr = 1'b1; end
        OPC_XNOR: begin ctrl.fn = FN_XOR; ctrl.inv = 1'b1; ctrl.wr = 1'b1; end
        OPC_SLL:  begin ctrl.fn = FN_SLL; ctrl.sext = 1'b1; ctrl.wr = 1'b1; end
        OPC_SRL:  begin ctrl.fn = FN_SRL; ctrl.sext = 1'b1; ctrl.wr = 1'b1; end
        OPC_SRA:  begin ctrl.fn = FN_SRA; ctrl.sext = 1'b1; ctrl.wr = 1'b1; end
        OPC_UPI:  begin ctrl.fn = FN_UPI; ctrl.wr = imm_form; end
        OPC_LDW:  begin ctrl.sext = 1'b1; ctrl.ld = imm_form; end
        OPC_STW:  begin ctrl.sext = 1'b1; ctrl.st = imm_form; end
        default:  ctrl.wr = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ieu_alu.sv
module ieu_alu
  import ieu_pkg::*;
(
  input  ctrl_t           ctrl,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] src2,
  output logic [XLEN-1:0] res,
  output logic [XLEN-1:0] addr
);
  localparam int EXTW = XLEN - IMMW;

  logic [XLEN-1:0] imm_s, imm_z, imm_x, b, raw, eff;
  logic [SHW-1:0]  shamt;
  logic signed [2*IMMW-1:0] prod;

  assign imm_s = {{EXTW{ctrl.imm[IMMW-1]}}, ctrl.imm};
  assign imm_z = {{EXTW{1'b0}}, ctrl.imm};
  assign imm_x = ctrl.sext ? imm_s : imm_z;
  assign b     = ctrl.use_imm ? imm_x : src2;
  assign shamt = b[SHW-1:0];
  assign prod  = $signed(a[IMMW-1:0]) * $signed(b[IMMW-1:0]);

  always_comb begin
    unique case (ctrl.fn)
      FN_ADD:  raw = a + b;
      FN_SUB:  raw = a - b;
      FN_AND:  raw = a & b;
      FN_OR:   raw = a | b;
      FN_XOR:  raw = a ^ b;
      FN_SLL:  raw = a << shamt;
      FN_SRL:  raw = a >> shamt;
      FN_SRA:  raw = $unsigned($signed(a) >>> shamt);
      FN_MUL:  raw = XLEN'(prod);
      FN_UPI:  raw = {ctrl.imm, {EXTW{1'b0}}};
      default: raw = '0;
    endcase
  end

  assign res  = ctrl.inv ? ~raw : raw;
  assign eff  = a + imm_s;
  assign addr = {eff[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  instr,
  input  logic [XLEN-1:0]  src1_val,
  input  logic [XLEN-1:0]  src2_val,
  output logic             out_valid,
  output logic [RIDX-1:0]  dest_idx,
  output logic             wr_en,
  output logic [XLEN-1:0]  result,
  output logic [XLEN-1:0]  mem_addr,
  output logic             mem_rd,
  output logic             mem_wr
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] alu_res, alu_addr;

  ieu_decode u_dec (.instr(instr), .ctrl(ctrl));
  ieu_alu    u_alu (.ctrl(ctrl), .a(src1_val), .src2(src2_val),
                    .res(alu_res), .addr(alu_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      dest_idx  <= '0;
      result    <= '0;
      mem_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & ctrl.wr;
      mem_rd    <= in_valid & ctrl.ld;
      mem_wr    <= in_valid & ctrl.st;
      if (in_valid) begin
        dest_idx <= ctrl.dest;
        result   <= ctrl.st ? src2_val : alu_res;
        mem_addr <= alu_addr;
      end
    end
  end

  assert_wide_fmt_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31]) |=> (!wr_en && !mem_rd && !mem_wr));

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && !mem_rd && !mem_wr));

  assert_upper_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[31] && instr[30:25] == 6'h0e && instr[24])
      |=> (wr_en && result[IMMW-1:0] == '0));

  assert_one_action_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, mem_rd, mem_wr}));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && !mem_rd && !mem_wr));
endmodule

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, src1_val, src2_val;
  logic        out_valid, wr_en, mem_rd, mem_wr;
  logic [3:0]  dest_idx;
  logic [31:0] result, mem_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  int_exec_unit dut (.*);

  function automatic logic [31:0] rform(input logic [5:0] op, input logic [3:0] d);
    return {1'b0, op, 1'b0, 4'h1, 4'h2, d, 12'h000};
  endfunction

  function automatic logic [31:0] iform(input logic [5:0] op, input logic [3:0] d,
                                        input logic [15:0] imm);
    return {1'b0, op, 1'b1, 4'h1, d, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = w; src1_val = a; src2_val = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_wr(input string tag, input logic [3:0] d, input logic [31:0] v);
    chk({tag, " result"}, result, v);
    chk({tag, " dest"}, {28'h0, dest_idx}, {28'h0, d});
    chk({tag, " wr_en"}, {31'h0, wr_en}, 32'h1);
  endtask

  task automatic t_reset;
    chk("R11 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R11 strobes", {29'h0, wr_en, mem_rd, mem_wr}, 32'h0);
  endtask

  task automatic t_signed;
    issue(rform(6'h00, 4'h5), 32'h7fffffff, 32'h1);
    expect_wr("R2 R1 add reg", 4'h5, 32'h80000000);
    chk("R10 out_valid", {31'h0, out_valid}, 32'h1);
    issue(iform(6'h00, 4'h7, 16'hffff), 32'h100, 32'hdead);
    expect_wr("R2 R1 add imm sext", 4'h7, 32'h000000ff);
    issue(iform(6'h02, 4'h9, 16'h8000), 32'h10, 32'h0);
    expect_wr("R2 sub imm sext", 4'h9, 32'h00008010);
  endtask

  task automatic t_unsigned;
    issue(iform(6'h01, 4'h2, 16'hffff), 32'h10, 32'h0);
    expect_wr("R3 addu imm zext", 4'h2, 32'h0001000f);
    issue(iform(6'h03, 4'h4, 16'h0001), 32'h10000, 32'h0);
    expect_wr("R3 subu imm", 4'h4, 32'h0000ffff);
    issue(rform(6'h03, 4'hc), 32'h0, 32'h1);
    expect_wr("R3 subu reg wrap", 4'hc, 32'hffffffff);
  endtask

  task automatic t_logic;
    issue(iform(6'h08, 4'h1, 16'hf0f0), 32'hffff1234, 32'h0);
    expect_wr("R4 and imm", 4'h1, 32'h00001030);
    issue(iform(6'h0b, 4'h1, 16'hf0f0), 32'hffff1234, 32'h0);
    expect_wr("R4 nand imm", 4'h1, 32'hffffefcf);
    issue(rform(6'h09, 4'h3), 32'hf0, 32'h0f);
    expect_wr("R4 or reg", 4'h3, 32'h000000ff);
    issue(rform(6'h0c, 4'h3), 32'hf0, 32'h0f);
    expect_wr("R4 nor reg", 4'h3, 32'hffffff00);
    issue(iform(6'h0a, 4'h6, 16'h8000), 32'h0, 32'h0);
    expect_wr("R4 xor imm zext", 4'h6, 32'h00008000);
    issue(iform(6'h0d, 4'h6, 16'hffff), 32'hffff0000, 32'h0);
    expect_wr("R4 xnor imm", 4'h6, 32'h00000000);
  endtask

  task automatic t_shift;
    issue(rform(6'h10, 4'h8), 32'h1, 32'd33);
    expect_wr("R5 sll wrap", 4'h8, 32'h00000002);
    issue(iform(6'h11, 4'h8, 16'h0004), 32'h80000000, 32'h0);
    expect_wr("R5 srl imm", 4'h8, 32'h08000000);
    issue(rform(6'h12, 4'h8), 32'h80000000, 32'd4);
    expect_wr("R5 sra reg", 4'h8, 32'hf8000000);
    issue(iform(6'h12, 4'h8, 16'h0024), 32'h80000000, 32'h0);
    expect_wr("R5 sra imm wrap", 4'h8, 32'hf8000000);
  endtask

  task automatic t_mul;
    issue(rform(6'h04, 4'ha), 32'h1234fffe, 32'habcd0003);
    expect_wr("R6 mul reg", 4'ha, 32'hfffffffa);
    issue(iform(6'h04, 4'ha, 16'h8000), 32'h00007fff, 32'h0);
    expect_wr("R6 mul imm", 4'ha, 32'hc0008000);
  endtask

  task automatic t_upper;
    issue(iform(6'h0e, 4'h3, 16'hbeef), 32'h12345678, 32'h0);
    expect_wr("R7 upper imm", 4'h3, 32'hbeef0000);
    issue(rform(6'h0e, 4'h3), 32'h1, 32'h1);
    chk("R7 reg form no write", {31'h0, wr_en}, 32'h0);
  endtask

  task automatic t_mem;
    issue(iform(6'h20, 4'hb, 16'h0002), 32'h1007, 32'h0);
    chk("R8 load addr", mem_addr, 32'h00001008);
    chk("R8 load strobes", {29'h0, wr_en, mem_rd, mem_wr}, 32'h2);
    chk("R8 load dest", {28'h0, dest_idx}, 32'hb);
    issue(iform(6'h21, 4'h2, 16'hffff), 32'h2000, 32'hcafebabe);
    chk("R8 store addr", mem_addr, 32'h00001ffc);
    chk("R8 store strobes", {29'h0, wr_en, mem_rd, mem_wr}, 32'h1);
    chk("R8 store data", result, 32'hcafebabe);
    issue(rform(6'h20, 4'hb), 32'h1000, 32'h0);
    chk("R8 load reg form ignored", {29'h0, wr_en, mem_rd, mem_wr}, 32'h0);
  endtask

  task automatic t_ignored;
    issue(32'h80000000 | rform(6'h00, 4'h5), 32'h1, 32'h1);
    chk("R9 wide format", {29'h0, wr_en, mem_rd, mem_wr}, 32'h0);
    issue(rform(6'h05, 4'h5), 32'h1, 32'h1);
    chk("R9 unknown opcode", {29'h0, wr_en, mem_rd, mem_wr}, 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr = rform(6'h00, 4'h5); src1_val = 32'h1; src2_val = 32'h1; in_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle valid", {31'h0, out_valid}, 32'h0);
    chk("R10 idle no write", {29'h0, wr_en, mem_rd, mem_wr}, 32'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; src1_val = '0; src2_val = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_signed();
    t_unsigned();
    t_logic();
    t_shift();
    t_mul();
    t_upper();
    t_mem();
    t_ignored();
    t_idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule